// File: doc/BRIEF.md
# Global Clock Source Control Mux

This block decides which of six candidate clocks reaches one global clock net. The candidates are two dedicated clock pins, two PLL outputs, one dual-purpose clock pin and one clock produced by internal logic. Selection works in two tiers. A 2-bit runtime select picks one clock from the group of pins and PLL outputs. A static source choice, captured only while reset is high, then routes that dynamic group, the dual-purpose pin or the internal clock onward. A runtime enable gates the final output.

Every selection point uses the same glitch-free handover cell. The cell drops the outgoing source on that source's falling edge through a two-stage synchronizer. It raises the incoming source in the incoming clock's own domain only after it has seen the outgoing source go off, so the net stays low during the handover and never carries a runt phase. A separate 2:1 handover cell chooses the PLL reference from two input clocks under a runtime switch.

Top module: `gclk_ctrl`

## Requirements
- R1: In dynamic mode the runtime select routes pin_clk_a on code 00, pin_clk_b on code 01, pll_c0 on code 10 and pll_c1 on code 11 to gclk_out.
- R2: The static source code is captured on rising ctl_clk edges while rst is high. Codes 00 and 11 route the dynamic group, 01 routes dp_clk and 10 routes int_clk.
- R3: Changes on cfg_src_in while rst is low have no effect on the routed source.
- R4: While the static choice is dp_clk or int_clk, dyn_sel has no effect on gclk_out.
- R5: Across a change of dyn_sel, gclk_out stays low during the handover. It shows no high or low phase shorter than half the period of the faster of the old and new sources, and at most one source of a group is enabled at any time.
- R6: With gclk_en low, gclk_out is held low once SYNC_STAGES falling edges of the routed clock have passed. With gclk_en high again, it carries the routed clock.
- R7: Toggling gclk_en at arbitrary times never produces a phase on gclk_out shorter than half the routed clock's period.
- R8: pll_ref_out carries ref_in0 when ref_sw is 0 and ref_in1 when ref_sw is 1. A switch produces no phase shorter than half the faster input's period, and at most one input is enabled at a time.
- R9: While rst is high, gclk_out and pll_ref_out are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctl_clk | input | 1 | Control clock that captures the static source code |
| rst | input | 1 | Active-high reset; static code is loaded while high |
| cfg_src_in | input | 2 | Static source code (00/11 dynamic, 01 dual-purpose, 10 internal) |
| pin_clk_a | input | 1 | Dedicated clock pin, dynamic code 00 |
| pin_clk_b | input | 1 | Dedicated clock pin, dynamic code 01 |
| pll_c0 | input | 1 | PLL output, dynamic code 10 |
| pll_c1 | input | 1 | PLL output, dynamic code 11 |
| dp_clk | input | 1 | Dual-purpose clock pin |
| int_clk | input | 1 | Clock generated by internal logic |
| dyn_sel | input | 2 | Runtime select within the dynamic group |
| gclk_en | input | 1 | Runtime enable of the global clock output |
| ref_in0 | input | 1 | PLL reference candidate for switch value 0 |
| ref_in1 | input | 1 | PLL reference candidate for switch value 1 |
| ref_sw | input | 1 | Runtime PLL reference switch |
| gclk_out | output | 1 | Global clock net |
| pll_ref_out | output | 1 | Selected PLL reference clock |

## Verification
The properties sample the handover state on ctl_clk. They assume that the control clock runs and that every candidate clock keeps toggling, because a stopped outgoing source would stall its own turn-off and hold the group dark. They also assume that dyn_sel, gclk_en and ref_sw are settled levels and not pulses narrower than a few source periods. The stimulus drives these controls between ctl_clk edges, holds each select value for hundreds of nanoseconds against source periods of at most 26 ns, and keeps every clock generator free-running for the whole run.

// File: rtl/gclk_pkg.sv
`timescale 1ns/1ps
package gclk_pkg;

  // Static source codes; 2'b11 is folded onto the dynamic group.
  typedef enum logic [1:0] {
    SRC_DYN     = 2'b00,
    SRC_DPIN    = 2'b01,
    SRC_INT     = 2'b10,
    SRC_DYN_ALT = 2'b11
  } src_cfg_e;

  localparam int unsigned SEL_W  = 2;
  localparam int unsigned N_DYN  = 1 << SEL_W;
  localparam int unsigned N_TOP  = 3;
  localparam int unsigned N_REF  = 2;

  // Tier-two one-hot: bit0 dynamic group, bit1 dual-purpose pin, bit2 internal.
  function automatic logic [N_TOP-1:0] cfg_to_onehot(input src_cfg_e c);
    logic [N_TOP-1:0] oh;
    case (c)
      SRC_DPIN: oh = 3'b010;
      SRC_INT:  oh = 3'b100;
      default:  oh = 3'b001;
    endcase
    return oh;
  endfunction

endpackage

// File: rtl/gclk_cfg_reg.sv
`timescale 1ns/1ps
module gclk_cfg_reg
  import gclk_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic [1:0] cfg_in,
  output src_cfg_e cfg_q
);

  // Loaded only while reset is held; frozen for the rest of the run.
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= src_cfg_e'(cfg_in);
    end
  end

endmodule

// File: rtl/gclk_gf_mux.sv
`timescale 1ns/1ps
module gclk_gf_mux #(
  parameter int unsigned N           = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic [N-1:0] clk_in,
  input  logic         rst,
  input  logic [N-1:0] sel_oh,
  output logic [N-1:0] on_q,
  output logic         clk_out
);

  logic [N-1:0] gated;

  for (genvar i = 0; i < N; i++) begin : g_src
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   others_on;
    logic                   req;

    // A source may turn on only once every other source reports off.
    assign others_on = |(on_q & ~(N'(1) << i));
    assign req       = sel_oh[i] & ~others_on;

    // Falling-edge chain: the enable moves only while this clock is low.
    // Reset is asserted asynchronously since a cascaded clock is stopped in reset.
    always_ff @(negedge clk_in[i] or posedge rst) begin
      if (rst) begin
        sync_q <= '0;
      end else begin
        sync_q <= {sync_q[SYNC_STAGES-2:0], req};
      end
    end

    assign on_q[i]  = sync_q[SYNC_STAGES-1];
    assign gated[i] = clk_in[i] & on_q[i];
  end

  assign clk_out = |gated;

endmodule

// File: rtl/gclk_ctrl.sv
`timescale 1ns/1ps
module gclk_ctrl
  import gclk_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             ctl_clk,
  input  logic             rst,
  input  logic [1:0]       cfg_src_in,
  input  logic             pin_clk_a,
  input  logic             pin_clk_b,
  input  logic             pll_c0,
  input  logic             pll_c1,
  input  logic             dp_clk,
  input  logic             int_clk,
  input  logic [SEL_W-1:0] dyn_sel,
  input  logic             gclk_en,
  input  logic             ref_in0,
  input  logic             ref_in1,
  input  logic             ref_sw,
  output logic             gclk_out,
  output logic             pll_ref_out
);

  src_cfg_e         cfg_q;
  logic [N_TOP-1:0] cfg_oh;

  logic [N_DYN-1:0] dyn_clks;
  logic [N_DYN-1:0] dyn_oh;
  logic [N_DYN-1:0] dyn_on;
  logic             dyn_clk;

  logic [N_TOP-1:0] top_clks;
  logic [N_TOP-1:0] top_on;
  logic             top_clk;

  logic [0:0]       gate_on;

  logic [N_REF-1:0] ref_clks;
  logic [N_REF-1:0] ref_oh;
  logic [N_REF-1:0] ref_on;

  // Static source choice.
  gclk_cfg_reg u_cfg (
    .clk    (ctl_clk),
    .rst    (rst),
    .cfg_in (cfg_src_in),
    .cfg_q  (cfg_q)
  );

  assign cfg_oh = cfg_to_onehot(cfg_q);

  // Tier one: runtime choice among pins and PLL outputs.
  assign dyn_clks = {pll_c1, pll_c0, pin_clk_b, pin_clk_a};
  assign dyn_oh   = N_DYN'(1) << dyn_sel;

  gclk_gf_mux #(.N(N_DYN), .SYNC_STAGES(SYNC_STAGES)) u_dyn_mux (
    .clk_in  (dyn_clks),
    .rst     (rst),
    .sel_oh  (dyn_oh),
    .on_q    (dyn_on),
    .clk_out (dyn_clk)
  );

  // Tier two: static choice among dynamic group, dual-purpose pin, internal.
  assign top_clks = {int_clk, dp_clk, dyn_clk};

  gclk_gf_mux #(.N(N_TOP), .SYNC_STAGES(SYNC_STAGES)) u_src_mux (
    .clk_in  (top_clks),
    .rst     (rst),
    .sel_oh  (cfg_oh),
    .on_q    (top_on),
    .clk_out (top_clk)
  );

  // Output enable: a single-source handover cell samples the enable on falling edges.
  gclk_gf_mux #(.N(1), .SYNC_STAGES(SYNC_STAGES)) u_gate (
    .clk_in  (top_clk),
    .rst     (rst),
    .sel_oh  (gclk_en),
    .on_q    (gate_on),
    .clk_out (gclk_out)
  );

  // PLL reference switch.
  assign ref_clks = {ref_in1, ref_in0};
  assign ref_oh   = {ref_sw, ~ref_sw};

  gclk_gf_mux #(.N(N_REF), .SYNC_STAGES(SYNC_STAGES)) u_ref_mux (
    .clk_in  (ref_clks),
    .rst     (rst),
    .sel_oh  (ref_oh),
    .on_q    (ref_on),
    .clk_out (pll_ref_out)
  );

endmodule

// File: rtl/gclk_ctrl_chk.sv
`timescale 1ns/1ps
module gclk_ctrl_chk (
  input logic       ctl_clk,
  input logic       rst,
  input logic [1:0] cfg_q,
  input logic [3:0] dyn_on,
  input logic [2:0] top_on,
  input logic       gate_on,
  input logic [1:0] ref_on,
  input logic       gclk_out
);

  // R3
  cfg_frozen_chk: assert property (@(posedge ctl_clk) disable iff (rst)
    !$past(rst) |-> $stable(cfg_q));

  // R2
  int_route_chk: assert property (@(posedge ctl_clk) disable iff (rst)
    (cfg_q == 2'b10) |-> (top_on[1:0] == 2'b00));

  // R4
  dyn_blocked_chk: assert property (@(posedge ctl_clk) disable iff (rst)
    (cfg_q == 2'b01) |-> (!top_on[0] && !top_on[2]));

  // R5
  dyn_onehot_chk: assert property (@(posedge ctl_clk) disable iff (rst)
    $onehot0(dyn_on));

  // R5
  top_onehot_chk: assert property (@(posedge ctl_clk) disable iff (rst)
    $onehot0(top_on));

  // R6
  gate_hold_chk: assert property (@(posedge ctl_clk) disable iff (rst)
    gclk_out |-> gate_on);

  // R8
  ref_onehot_chk: assert property (@(posedge ctl_clk) disable iff (rst)
    $onehot0(ref_on));

endmodule

bind gclk_ctrl gclk_ctrl_chk chk_i (
  .ctl_clk  (ctl_clk),
  .rst      (rst),
  .cfg_q    (cfg_q),
  .dyn_on   (dyn_on),
  .top_on   (top_on),
  .gate_on  (gate_on[0]),
  .ref_on   (ref_on),
  .gclk_out (gclk_out)
);

// File: tb/gclk_ctrl_tb_top.sv
`timescale 1ns/1ps
module gclk_ctrl_tb_top;

  logic       ctl_clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cfg_src_in = 2'b00;
  logic       pin_clk_a = 1'b0;
  logic       pin_clk_b = 1'b0;
  logic       pll_c0 = 1'b0;
  logic       pll_c1 = 1'b0;
  logic       dp_clk = 1'b0;
  logic       int_clk = 1'b0;
  logic [1:0] dyn_sel = 2'b00;
  logic       gclk_en = 1'b1;
  logic       ref_in0 = 1'b0;
  logic       ref_in1 = 1'b0;
  logic       ref_sw = 1'b0;
  logic       gclk_out;
  logic       pll_ref_out;

  // Half periods in ns.
  localparam real HP_A   = 5.0;
  localparam real HP_B   = 7.0;
  localparam real HP_C0  = 3.0;
  localparam real HP_C1  = 11.0;
  localparam real HP_DP  = 9.0;
  localparam real HP_INT = 13.0;
  localparam real HP_R0  = 6.0;
  localparam real HP_R1  = 8.0;

  real hp_dyn [4] = '{HP_A, HP_B, HP_C0, HP_C1};

  int n_chk = 0;
  int n_bad = 0;

  realtime g_last = -1.0;
  realtime g_min  = 1.0e9;
  realtime r_last = -1.0;
  realtime r_min  = 1.0e9;

  always #4 ctl_clk = ~ctl_clk;
  always #(HP_A)   pin_clk_a = ~pin_clk_a;
  always #(HP_B)   pin_clk_b = ~pin_clk_b;
  always #(HP_C0)  pll_c0    = ~pll_c0;
  always #(HP_C1)  pll_c1    = ~pll_c1;
  always #(HP_DP)  dp_clk    = ~dp_clk;
  always #(HP_INT) int_clk   = ~int_clk;
  always #(HP_R0)  ref_in0   = ~ref_in0;
  always #(HP_R1)  ref_in1   = ~ref_in1;

  gclk_ctrl dut_i (
    .ctl_clk     (ctl_clk),
    .rst         (rst),
    .cfg_src_in  (cfg_src_in),
    .pin_clk_a   (pin_clk_a),
    .pin_clk_b   (pin_clk_b),
    .pll_c0      (pll_c0),
    .pll_c1      (pll_c1),
    .dp_clk      (dp_clk),
    .int_clk     (int_clk),
    .dyn_sel     (dyn_sel),
    .gclk_en     (gclk_en),
    .ref_in0     (ref_in0),
    .ref_in1     (ref_in1),
    .ref_sw      (ref_sw),
    .gclk_out    (gclk_out),
    .pll_ref_out (pll_ref_out)
  );

  // Shortest phase seen on each output since the last clear.
  always @(gclk_out) begin
    if (!rst && g_last >= 0.0 && ($realtime - g_last) < g_min) g_min = $realtime - g_last;
    g_last = $realtime;
  end

  always @(pll_ref_out) begin
    if (!rst && r_last >= 0.0 && ($realtime - r_last) < r_min) r_min = $realtime - r_last;
    r_last = $realtime;
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input real act, input real exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0.2f expected %0.2f", tag, what, act, exp);
    end
  endtask

  task automatic measure(input bit use_ref, output real p);
    realtime t0;
    if (use_ref) begin
      @(posedge pll_ref_out); t0 = $realtime;
      @(posedge pll_ref_out);
    end else begin
      @(posedge gclk_out); t0 = $realtime;
      @(posedge gclk_out);
    end
    p = $realtime - t0;
  endtask

  function automatic bit near(input real a, input real b);
    return (a - b < 0.01) && (b - a < 0.01);
  endfunction

  task automatic do_reset(input logic [1:0] cfg);
    @(negedge ctl_clk);
    rst = 1'b1;
    cfg_src_in = cfg;
    repeat (20) @(negedge ctl_clk);
    // R9: both outputs low while reset is held
    check(gclk_out === 1'b0, "R9", "gclk_out in reset", real'(gclk_out), 0.0);
    check(pll_ref_out === 1'b0, "R9", "pll_ref_out in reset", real'(pll_ref_out), 0.0);
    rst = 1'b0;
    repeat (4) @(negedge ctl_clk);
  endtask

  task automatic t_dyn_switch();
    int  seq [8] = '{0, 1, 2, 3, 0, 2, 1, 3};
    int  prev = 0;
    real p;
    real lim;
    for (int k = 0; k < 8; k++) begin
      @(negedge ctl_clk);
      g_min = 1.0e9;
      dyn_sel = 2'(seq[k]);
      #400;
      measure(1'b0, p);
      // R1: period of the routed dynamic source
      check(near(p, 2.0 * hp_dyn[seq[k]]), "R1", "dynamic period", p, 2.0 * hp_dyn[seq[k]]);
      lim = (hp_dyn[prev] < hp_dyn[seq[k]]) ? hp_dyn[prev] : hp_dyn[seq[k]];
      // R5: no runt phase across the handover
      check(g_min >= lim - 0.01, "R5", "min phase on switch", g_min, lim);
      prev = seq[k];
    end
  endtask

  task automatic t_enable();
    int  hi = 0;
    real p;
    @(negedge ctl_clk);
    dyn_sel = 2'b00;
    #300;
    @(negedge ctl_clk);
    g_min = 1.0e9;
    gclk_en = 1'b0;
    #100;
    for (int k = 0; k < 200; k++) begin
      #1;
      if (gclk_out !== 1'b0) hi++;
    end
    // R6: held low while disabled
    check(hi == 0, "R6", "high samples while disabled", real'(hi), 0.0);
    gclk_en = 1'b1;
    #100;
    measure(1'b0, p);
    // R6: output resumes with the routed clock
    check(near(p, 2.0 * HP_A), "R6", "period after re-enable", p, 2.0 * HP_A);
    // R7: no runt phase from a single off/on cycle
    check(g_min >= HP_A - 0.01, "R7", "min phase enable cycle", g_min, HP_A);
    g_min = 1.0e9;
    for (int k = 0; k < 30; k++) begin
      #13;
      gclk_en = ~gclk_en;
    end
    gclk_en = 1'b1;
    #100;
    // R7: no runt phase under rapid enable toggling
    check(g_min >= HP_A - 0.01, "R7", "min phase enable toggling", g_min, HP_A);
  endtask

  task automatic t_static();
    real p;
    do_reset(2'b01);
    #300;
    measure(1'b0, p);
    // R2: code 01 routes the dual-purpose pin
    check(near(p, 2.0 * HP_DP), "R2", "dual-purpose period", p, 2.0 * HP_DP);
    for (int s = 0; s < 4; s++) begin
      @(negedge ctl_clk);
      dyn_sel = 2'(s);
      #200;
      measure(1'b0, p);
      // R4: dyn_sel has no effect under a static choice
      check(near(p, 2.0 * HP_DP), "R4", "period with dyn_sel moved", p, 2.0 * HP_DP);
    end
    @(negedge ctl_clk);
    cfg_src_in = 2'b10;
    #300;
    measure(1'b0, p);
    // R3: configuration change outside reset ignored
    check(near(p, 2.0 * HP_DP), "R3", "period after late cfg write", p, 2.0 * HP_DP);
    do_reset(2'b10);
    @(negedge ctl_clk);
    dyn_sel = 2'b10;
    #300;
    measure(1'b0, p);
    // R2: code 10 routes the internal clock; R4 dyn_sel ignored
    check(near(p, 2.0 * HP_INT), "R2", "internal period", p, 2.0 * HP_INT);
    do_reset(2'b11);
    @(negedge ctl_clk);
    dyn_sel = 2'b01;
    #300;
    measure(1'b0, p);
    // R2: code 11 behaves as the dynamic group
    check(near(p, 2.0 * HP_B), "R2", "code 11 dynamic period", p, 2.0 * HP_B);
    do_reset(2'b00);
  endtask

  task automatic t_ref_switch();
    real p;
    @(negedge ctl_clk);
    ref_sw = 1'b0;
    #300;
    measure(1'b1, p);
    // R8: switch 0 selects ref_in0
    check(near(p, 2.0 * HP_R0), "R8", "reference period sw=0", p, 2.0 * HP_R0);
    @(negedge ctl_clk);
    r_min = 1.0e9;
    ref_sw = 1'b1;
    #300;
    measure(1'b1, p);
    // R8: switch 1 selects ref_in1
    check(near(p, 2.0 * HP_R1), "R8", "reference period sw=1", p, 2.0 * HP_R1);
    @(negedge ctl_clk);
    ref_sw = 1'b0;
    #300;
    measure(1'b1, p);
    check(near(p, 2.0 * HP_R0), "R8", "reference period back to sw=0", p, 2.0 * HP_R0);
    // R8: no runt phase across both switches
    check(r_min >= HP_R0 - 0.01, "R8", "reference min phase", r_min, HP_R0);
  endtask

  initial begin
    do_reset(2'b00);
    t_dyn_switch();
    t_enable();
    t_static();
    t_ref_switch();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000.0 * 8.0);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule